// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block moves an asynchronous DRAM into its low-power self-refresh state and back out again. A request from the system starts a refresh-style entry: both byte column strobes fall while the row strobe is still high, and then the row strobe falls. Both strobes then stay low for a long minimum interval, and after that the DRAM refreshes itself for as long as the row strobe stays low. A wake request raises the row strobe. The block then waits out a precharge interval before it reports itself ready for new traffic.

Every interval is a parameter given in nanoseconds. A package function converts each one to a whole number of controller clocks, rounding up. One down-counter times whichever interval is active. The address bus is held at zero for the whole sequence. Arbitration between sleeping and normal traffic belongs to the surrounding wrapper.

Top module: `srm_ctrl`

## Requirements
- R1: While reset is high and on release, ready=1, ras_n=1, ucas_n=1, lcas_n=1 and addr=0.
- R2: A sleep_req sampled high while ready drops ready at that clock edge. For the next ceil(T_RPC_NS/CLK_NS) cycles, ras_n and both CAS strobes stay high.
- R3: Both CAS strobes then go low with ras_n still high, for exactly ceil(T_CSR_NS/CLK_NS) cycles, before ras_n falls.
- R4: ucas_n and lcas_n are always equal.
- R5: After ras_n falls, ras_n and both CAS strobes stay low for at least ceil(T_HOLD_NS/CLK_NS) cycles. A wake_req that is high only during that interval has no effect.
- R6: Once the minimum hold has passed, the strobes stay low until wake_req is sampled high. At that edge ras_n and both CAS strobes return high together. A wake_req held high from inside the hold interval exits on the first cycle after the hold ends.
- R7: After exit, ready stays low for exactly ceil(T_RPS_NS/CLK_NS) cycles with all strobes high. It then returns to 1, and a new sleep_req is accepted on the next cycle.
- R8: wake_req while ready has no effect. A sleep_req while not ready (including during the exit precharge) has no effect.
- R9: addr is 0 at all times.
- R10: Each interval is rounded up to whole cycles (for example 72 ns at a 5 ns clock gives 15 cycles), with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter self-refresh, honoured only while ready |
| wake_req | input | 1 | Level request to leave self-refresh, honoured only after the minimum hold |
| ready | output | 1 | High when the DRAM is idle and available for traffic |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| addr | output | ADDR_W | Multiplexed address bus, held at zero |

## Verification
The assertions assume that sleep_req and wake_req are synchronous to clk and that reset is asserted from time zero until the first edges have loaded the idle state. The hold and precharge checks count strobe cycles from the pins alone. They therefore also rely on the interval parameters being at least one cycle. The stimulus changes both requests only on the falling clock edge. It places wake pulses in the idle state, inside the hold interval, after the hold, and as a level that spans the end of the hold. It also sends a sleep pulse inside the exit precharge, so every ignored request lands in a state where it must be dropped.

// File: rtl/srm_pkg.sv
package srm_pkg;

    typedef enum logic [2:0] {
        SR_IDLE,
        SR_SETTLE,
        SR_CAS_LEAD,
        SR_ENTRY_HOLD,
        SR_ASLEEP,
        SR_RECOVER
    } sr_state_e;

    typedef struct packed {
        logic ready;
        logic row_low;
        logic col_low;
    } sr_drive_t;

    // Round a time in ns up to whole clocks, never below one cycle.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned clk_ns);
        int unsigned q;
        q = (t_ns + clk_ns - 1) / clk_ns;
        return (q == 0) ? 1 : q;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srm_interval_timer.sv
module srm_interval_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign expired = (count == '0);
endmodule

// File: rtl/srm_sequencer.sv
module srm_sequencer import srm_pkg::*; #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned RPC_CYC  = 1,
    parameter int unsigned CSR_CYC  = 1,
    parameter int unsigned HOLD_CYC = 1,
    parameter int unsigned RPS_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic             expired,
    output sr_state_e        state,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    sr_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            SR_IDLE:       if (sleep_req) nxt = SR_SETTLE;
            SR_SETTLE:     if (expired)   nxt = SR_CAS_LEAD;
            SR_CAS_LEAD:   if (expired)   nxt = SR_ENTRY_HOLD;
            SR_ENTRY_HOLD: if (expired)   nxt = SR_ASLEEP;
            SR_ASLEEP:     if (wake_req)  nxt = SR_RECOVER;
            SR_RECOVER:    if (expired)   nxt = SR_IDLE;
            default:                      nxt = SR_IDLE;
        endcase
    end

    // The timer is reloaded on every state change with the new dwell minus one.
    always_comb begin
        load     = (nxt != state);
        load_val = '0;
        case (nxt)
            SR_SETTLE:     load_val = CNT_W'(RPC_CYC - 1);
            SR_CAS_LEAD:   load_val = CNT_W'(CSR_CYC - 1);
            SR_ENTRY_HOLD: load_val = CNT_W'(HOLD_CYC - 1);
            SR_RECOVER:    load_val = CNT_W'(RPS_CYC - 1);
            default:       load_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SR_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/srm_pin_drive.sv
module srm_pin_drive import srm_pkg::*; #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned ADDR_W = 9
) (
    input  sr_state_e         state,
    output logic              ready,
    output logic              row_n,
    output logic [LANES-1:0]  col_n,
    output logic [ADDR_W-1:0] addr
);
    sr_drive_t drv;

    always_comb begin
        drv = '{ready: 1'b0, row_low: 1'b0, col_low: 1'b0};
        case (state)
            SR_IDLE:       drv.ready = 1'b1;
            SR_CAS_LEAD:   drv.col_low = 1'b1;
            SR_ENTRY_HOLD: begin drv.row_low = 1'b1; drv.col_low = 1'b1; end
            SR_ASLEEP:     begin drv.row_low = 1'b1; drv.col_low = 1'b1; end
            default:       drv = '{ready: 1'b0, row_low: 1'b0, col_low: 1'b0};
        endcase
    end

    assign ready = drv.ready;
    assign row_n = ~drv.row_low;
    assign addr  = '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign col_n[g] = ~drv.col_low;
    end
endmodule

// File: rtl/srm_ctrl.sv
module srm_ctrl import srm_pkg::*; #(
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned T_RPC_NS  = 10,
    parameter int unsigned T_CSR_NS  = 5,
    parameter int unsigned T_HOLD_NS = 100000,
    parameter int unsigned T_RPS_NS  = 70,
    parameter int unsigned ADDR_W    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic              wake_req,
    output logic              ready,
    output logic              ras_n,
    output logic              ucas_n,
    output logic              lcas_n,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned RPC_CYC  = ns_to_cycles(T_RPC_NS, CLK_NS);
    localparam int unsigned CSR_CYC  = ns_to_cycles(T_CSR_NS, CLK_NS);
    localparam int unsigned HOLD_CYC = ns_to_cycles(T_HOLD_NS, CLK_NS);
    localparam int unsigned RPS_CYC  = ns_to_cycles(T_RPS_NS, CLK_NS);
    localparam int unsigned MAX_CYC  = max2(max2(RPC_CYC, CSR_CYC), max2(HOLD_CYC, RPS_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
    localparam int unsigned LANES    = 2;

    sr_state_e        state;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic [LANES-1:0] col_n;

    srm_sequencer #(
        .CNT_W(CNT_W), .RPC_CYC(RPC_CYC), .CSR_CYC(CSR_CYC),
        .HOLD_CYC(HOLD_CYC), .RPS_CYC(RPS_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
        .expired(expired), .state(state), .load(load), .load_val(load_val)
    );

    srm_interval_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
    );

    srm_pin_drive #(.LANES(LANES), .ADDR_W(ADDR_W)) u_pins (
        .state(state), .ready(ready), .row_n(ras_n), .col_n(col_n), .addr(addr)
    );

    assign lcas_n = col_n[0];
    assign ucas_n = col_n[1];
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
    parameter int unsigned HOLD_CYC = 1,
    parameter int unsigned RPS_CYC  = 1,
    parameter int unsigned ADDR_W   = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              ras_n,
    input logic              ucas_n,
    input logic              lcas_n,
    input logic [ADDR_W-1:0] addr
);
    localparam int unsigned LIM = ((HOLD_CYC > RPS_CYC) ? HOLD_CYC : RPS_CYC) + 2;
    localparam int unsigned W   = $clog2(LIM + 1);

    logic [W-1:0] low_run;
    logic [W-1:0] high_run;

    // Saturating run lengths of the row strobe, measured at the pins.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= '0;
        end else begin
            low_run  <= ras_n ? '0 : ((low_run  == W'(LIM)) ? low_run  : low_run  + 1'b1);
            high_run <= ras_n ? ((high_run == W'(LIM)) ? high_run : high_run + 1'b1) : '0;
        end
    end

    a_r4_cas_pair: assert property (@(posedge clk) disable iff (rst) ucas_n == lcas_n);

    a_r9_addr_zero: assert property (@(posedge clk) disable iff (rst) addr == '0);

    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!ucas_n && !$past(ucas_n)));

    a_r2_busy_while_row_low: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> !ready);

    a_r5_min_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_run >= W'(HOLD_CYC)));

    a_r6_cas_released: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |=> (ucas_n && lcas_n));

    a_r7_precharge_done: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (high_run >= W'(RPS_CYC)));
endmodule

bind srm_ctrl srm_checker #(
    .HOLD_CYC(HOLD_CYC), .RPS_CYC(RPS_CYC), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .ready(ready), .ras_n(ras_n),
    .ucas_n(ucas_n), .lcas_n(lcas_n), .addr(addr)
);

// File: tb/sim_srm_ctrl.sv
`timescale 1ns/1ps
module sim_srm_ctrl;
    // Bench settings at a 5 ns clock, rounded up by hand from the requirements.
    localparam int NRPC  = 2;    // 10 ns
    localparam int NCSR  = 1;    // 5 ns
    localparam int NHOLD = 400;  // 2000 ns
    localparam int NRPS  = 15;   // 72 ns rounds up (R10)

    localparam logic [3:0] K_IDLE = 4'b1111;  // {ready, ras_n, ucas_n, lcas_n}
    localparam logic [3:0] K_PRE  = 4'b0111;
    localparam logic [3:0] K_LEAD = 4'b0100;
    localparam logic [3:0] K_LOW  = 4'b0000;

    typedef struct {
        logic [3:0] key;
        int         len;
        string      tag;
    } seg_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0;
    logic wake_req = 1'b0;
    logic ready, ras_n, ucas_n, lcas_n;
    logic [8:0] addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    seg_t exp_q[$];

    always #2.5 clk = ~clk;

    srm_ctrl #(
        .CLK_NS(5), .T_RPC_NS(10), .T_CSR_NS(5), .T_HOLD_NS(2000),
        .T_RPS_NS(72), .ADDR_W(9)
    ) u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
        .ready(ready), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .addr(addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] key, input int len, input string tag);
        seg_t s;
        s.key = key; s.len = len; s.tag = tag;
        exp_q.push_back(s);
    endtask

    // Monitor: cuts the pin trace into constant segments and scores each one.
    initial begin
        logic [3:0] prev, cur;
        int len;
        bit addr_bad;
        wait (mon_on);
        prev = {ready, ras_n, ucas_n, lcas_n};
        len = 0;
        addr_bad = 1'b0;
        forever begin
            @(negedge clk);
            cur = {ready, ras_n, ucas_n, lcas_n};
            if (addr != '0) addr_bad = 1'b1;
            if (cur == prev) begin
                len++;
            end else begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected pin change", int'(cur), int'(prev));
                end else begin
                    seg_t e;
                    e = exp_q.pop_front();
                    chk(prev == e.key, {e.tag, " level"}, int'(prev), int'(e.key));
                    if (e.len != 0) chk(len == e.len, {e.tag, " length"}, len, e.len);
                end
                chk(prev[1] == prev[0], "R4 cas pair", int'(prev[1]), int'(prev[0]));
                chk(!addr_bad, "R9 addr zero", int'(addr_bad), 0);
                prev = cur;
                len = 1;
            end
        end
    end

    // Driver: one full sleep and wake round trip.
    // mode 0: wake after the hold; 1: wake poke in hold and sleep poke in exit;
    // 2: wake level raised inside the hold.
    task automatic run_cycle(input int extra, input int mode);
        int d;
        d = NRPC + NCSR + NHOLD + extra;
        push(K_IDLE, 0, "R1 idle");
        push(K_PRE, NRPC, "R2 settle");
        push(K_LEAD, NCSR, "R3 cas lead");
        push(K_LOW, (mode == 2) ? NHOLD + 1 : NHOLD + extra + 1, "R5 R6 asleep");
        push(K_PRE, NRPS, "R7 R10 precharge");
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        chk(ready == 1'b0, "R2 ready drop", int'(ready), 0);
        if (mode == 2) begin
            repeat (NRPC + NCSR + NHOLD / 2) @(negedge clk);
            wake_req = 1'b1;
            repeat (NHOLD - NHOLD / 2 + 1) @(negedge clk);
            chk(ras_n && ucas_n && lcas_n, "R6 level wake exit", int'(ras_n), 1);
            wake_req = 1'b0;
        end else begin
            if (mode == 1) begin
                repeat (NRPC + NCSR + 2) @(negedge clk);
                wake_req = 1'b1;
                @(negedge clk); wake_req = 1'b0;
                repeat (d - (NRPC + NCSR + 3)) @(negedge clk);
            end else begin
                repeat (d) @(negedge clk);
            end
            chk(!ras_n && !ucas_n, "R5 still asleep", int'(ras_n), 0);
            wake_req = 1'b1;
            @(negedge clk); wake_req = 1'b0;
            chk(ras_n && ucas_n && lcas_n, "R6 wake exit", int'(ras_n), 1);
        end
        if (mode == 1) begin
            @(negedge clk); sleep_req = 1'b1;
            @(negedge clk); sleep_req = 1'b0;
            repeat (NRPS) @(negedge clk);
            chk(ready == 1'b1, "R7 ready back", int'(ready), 1);
            repeat (6) @(negedge clk);
            chk(ready && ras_n, "R8 sleep in exit ignored", int'(ready), 1);
        end else begin
            repeat (NRPS) @(negedge clk);
            chk(ready == 1'b1, "R7 ready back", int'(ready), 1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R1 reset ready", int'(ready), 1);
        chk(ras_n == 1'b1, "R1 reset ras_n", int'(ras_n), 1);
        chk(ucas_n && lcas_n, "R1 reset cas", int'(ucas_n), 1);
        chk(addr == '0, "R1 reset addr", int'(addr), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ready && ras_n && ucas_n && lcas_n, "R1 after release", int'(ready), 1);
        mon_on = 1'b1;

        // R8: wake while idle does nothing.
        @(negedge clk); wake_req = 1'b1;
        repeat (3) @(negedge clk); wake_req = 1'b0;
        chk(ready && ras_n, "R8 wake in idle ignored", int'(ready), 1);

        run_cycle(3, 0);
        run_cycle(0, 1);
        run_cycle(0, 2);   // starts right after ready returns
        run_cycle(7, 0);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all segments seen", exp_q.size(), 0);
        finish_run();
    end
endmodule